// File: doc/BRIEF.md
# Iterative Integer Divide and Remainder Unit

This block computes quotients and remainders of 64-bit integers one quotient bit per clock, using restoring long division on operand magnitudes. One datapath serves signed and unsigned operation, a 64-bit or 32-bit operand width, remainder instead of quotient, and an extended divide mode. In the extended mode the dividend is the first operand placed above a field of zeros as wide as the operands.

A request is sampled on `start` while the unit is idle. The operands and mode inputs only need to be valid in that cycle. Some results are known from the operands alone: division by zero, the most negative value divided by minus one, and an extended dividend too large for the divisor. For these the unit answers on the next cycle. Every other request iterates once per operand bit and then spends one cycle on the final sign and range correction.

When overflow is flagged the result is forced to zero. In 32-bit mode the upper half of the result is always zero. The result, overflow flag and condition field hold their values until the next completion.

Top module: `int_divmod`

## Requirements
- R1: After reset `busy`, `done`, `ovf`, `result` and `cond` are all zero.
- R2: Unsigned operation (`sgn`=0) returns the quotient `opa/opb`, or the remainder `opa%opb` when `rem_sel`=1, with `ovf`=0 for any nonzero divisor.
- R3: Signed operation truncates the quotient toward zero. The remainder carries the sign of the dividend.
- R4: With `word`=1 only bits 31:0 of each operand are used, and result bits 63:32 are zero.
- R5: A divisor whose used bits are all zero gives `ovf`=1 and `result`=0 in every mode.
- R6: In signed non-extended mode, the most negative value of the operand width divided by all ones gives `ovf`=1 and `result`=0, for both quotient and remainder. The same operands in unsigned mode do not overflow.
- R7: Unsigned extended divide (`ext`=1, `rem_sel`=0) divides `opa·2^W` by `opb`, where W is the operand width. It is valid only when `opa` < `opb`, and otherwise flags overflow.
- R8: Signed extended divide treats the shifted first operand as signed and the divisor as zero-extended. It flags overflow when the truncated quotient is outside the signed W-bit range.
- R9: `done` is a one-cycle pulse. It rises in the cycle after the `start` cycle for the operand-decided overflow cases of R5, R6 and R7, and for a signed extended dividend whose magnitude is not below the divisor. Otherwise it rises W+1 cycles after the cycle following `start`. `busy` is high from that cycle until `done`, and `start` while `busy` is ignored.
- R10: `cond` is one-hot when `done` is high. Bit 0 means the result is zero, bit 2 means bit W-1 of the result is set, and bit 1 covers every other result.
- R11: With `rem_sel`=1 the `ext` input has no effect. The plain remainder is returned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request, sampled when idle |
| opa | input | 64 | Dividend operand |
| opb | input | 64 | Divisor operand |
| sgn | input | 1 | Signed operation |
| word | input | 1 | 32-bit operand width |
| ext | input | 1 | Extended divide mode |
| rem_sel | input | 1 | Return remainder instead of quotient |
| busy | output | 1 | Iteration in progress |
| done | output | 1 | Result valid pulse |
| result | output | 64 | Quotient or remainder |
| ovf | output | 1 | Overflow flag |
| cond | output | 3 | Result sign/zero class, one-hot |

## Verification
The bench targets sign handling around the most negative value. A unit that negated through a narrow path would produce a wrong magnitude for minus two to the 63rd, or would miss the minus-one overflow. It also targets extended division at the exact fit boundary, where a quotient of minus 2^63 is legal and plus 2^63 is not. An off-by-one range check would flip the overflow flag there. Word mode is driven with garbage in the upper operand halves, which exposes any leak of unused bits into the magnitude or the result. Completion timing is counted cycle by cycle, including a second `start` raised mid-run, which a unit that restarted would turn into a wrong result.

// File: rtl/int_divmod.sv
module int_divmod #(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [XLEN-1:0] opa,
  input  logic [XLEN-1:0] opb,
  input  logic            sgn,
  input  logic            word,
  input  logic            ext,
  input  logic            rem_sel,
  output logic            busy,
  output logic            done,
  output logic [XLEN-1:0] result,
  output logic            ovf,
  output logic [2:0]      cond
);
  localparam int H  = XLEN / 2;
  localparam int CW = $clog2(XLEN + 1);
  localparam logic [XLEN-1:0] LIM_D = {1'b1, {(XLEN-1){1'b0}}};
  localparam logic [XLEN-1:0] LIM_W = {{H{1'b0}}, 1'b1, {(H-1){1'b0}}};

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_FIN} st_t;
  st_t st;

  logic [CW-1:0]   cnt;
  logic [XLEN-1:0] rem, quo, dvs;
  logic            word_q, rsel_q, sext_q, neg_q, neg_r;

  // operand conditioning at start
  logic            ext_eff, b_sgn, a_neg, b_neg;
  logic [XLEN-1:0] a_ext, b_ext, a_mag, b_mag, lim_in;
  logic            b_zero, minus1, ext_big, early;

  assign ext_eff = ext & ~rem_sel;
  assign b_sgn   = sgn & ~ext_eff;
  assign a_ext   = word ? {{H{sgn & opa[H-1]}}, opa[H-1:0]} : opa;
  assign b_ext   = word ? {{H{b_sgn & opb[H-1]}}, opb[H-1:0]} : opb;
  assign a_neg   = sgn & a_ext[XLEN-1];
  assign b_neg   = b_sgn & b_ext[XLEN-1];
  assign a_mag   = a_neg ? -a_ext : a_ext;
  assign b_mag   = b_neg ? -b_ext : b_ext;
  assign lim_in  = word ? LIM_W : LIM_D;
  assign b_zero  = (b_mag == '0);
  assign minus1  = b_sgn & a_neg & (a_mag == lim_in) & (b_ext == '1);
  assign ext_big = ext_eff & (a_mag >= b_mag);
  assign early   = b_zero | minus1 | ext_big;

  // one restoring step
  logic [XLEN:0] sh;
  logic          ge;
  assign sh = {rem, quo[XLEN-1]};
  assign ge = (sh >= {1'b0, dvs});

  // final correction
  logic [XLEN-1:0] q_mag, q_val, r_val, sel, fin, lim_q;
  logic            late_ovf, msb;
  assign q_mag    = word_q ? {{H{1'b0}}, quo[H-1:0]} : quo;
  assign q_val    = neg_q ? -q_mag : q_mag;
  assign r_val    = neg_r ? -rem : rem;
  assign lim_q    = word_q ? LIM_W : LIM_D;
  assign late_ovf = sext_q & (neg_q ? (q_mag > lim_q) : (q_mag >= lim_q));
  assign sel      = rsel_q ? r_val : q_val;
  assign fin      = late_ovf ? '0 : (word_q ? {{H{1'b0}}, sel[H-1:0]} : sel);
  assign msb      = word_q ? fin[H-1] : fin[XLEN-1];

  assign busy = (st != S_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      cnt    <= '0;
      rem    <= '0;
      quo    <= '0;
      dvs    <= '0;
      word_q <= 1'b0;
      rsel_q <= 1'b0;
      sext_q <= 1'b0;
      neg_q  <= 1'b0;
      neg_r  <= 1'b0;
      done   <= 1'b0;
      result <= '0;
      ovf    <= 1'b0;
      cond   <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          word_q <= word;
          rsel_q <= rem_sel;
          sext_q <= sgn & ext_eff;
          neg_q  <= a_neg ^ b_neg;
          neg_r  <= a_neg;
          if (early) begin
            result <= '0;
            ovf    <= 1'b1;
            cond   <= 3'b001;
            done   <= 1'b1;
          end else begin
            rem <= ext_eff ? a_mag : '0;
            quo <= ext_eff ? '0 : (word ? (a_mag << H) : a_mag);
            dvs <= b_mag;
            cnt <= word ? CW'(H) : CW'(XLEN);
            st  <= S_RUN;
          end
        end
        S_RUN: begin
          rem <= ge ? XLEN'(sh - {1'b0, dvs}) : sh[XLEN-1:0];
          quo <= {quo[XLEN-2:0], ge};
          cnt <= cnt - 1'b1;
          if (cnt == CW'(1)) st <= S_FIN;
        end
        default: begin
          result <= fin;
          ovf    <= late_ovf;
          cond   <= (fin == '0) ? 3'b001 : (msb ? 3'b100 : 3'b010);
          done   <= 1'b1;
          st     <= S_IDLE;
        end
      endcase
    end
  end
endmodule

module int_divmod_chk #(
  parameter int XLEN = 64
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start,
  input logic            busy,
  input logic            done,
  input logic [XLEN-1:0] result,
  input logic            ovf,
  input logic [2:0]      cond
);
  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy);
  // R9
  start_take_chk: assert property (@(posedge clk) disable iff (!rst_n) (start && !busy) |=> (busy || done));
  // R5
  ovf_zero_chk: assert property (@(posedge clk) disable iff (!rst_n) (done && ovf) |-> (result == '0));
  // R10
  cond_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> ($countones(cond) == 1));
  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n) (!done && !$past(!rst_n)) |-> $stable(result));
endmodule

bind int_divmod int_divmod_chk #(.XLEN(XLEN)) chk_i (.*);

// File: tb/int_divmod_tb_top.sv
`timescale 1ns/1ps
module int_divmod_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [63:0] opa = '0, opb = '0;
  logic        sgn = 1'b0, word = 1'b0, ext = 1'b0, rem_sel = 1'b0;
  logic        busy, done, ovf;
  logic [63:0] result;
  logic [2:0]  cond;
  int checks = 0, fails = 0;
  bit  finished = 0;

  always #2 clk = ~clk;

  int_divmod dut_i (.clk(clk), .rst_n(rst_n), .start(start), .opa(opa), .opb(opb),
    .sgn(sgn), .word(word), .ext(ext), .rem_sel(rem_sel), .busy(busy), .done(done),
    .result(result), .ovf(ovf), .cond(cond));

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic void ref_op(input logic [63:0] a, input logic [63:0] b,
      input logic s, input logic w, input logic e, input logic r,
      output logic [63:0] res, output logic ov, output logic [2:0] cnd, output int lat);
    int W = w ? 32 : 64;
    logic ee = e & ~r;
    logic signed [129:0] A, B, Q, R, lo, hi, am, val;
    logic early;
    A = w ? (s ? {{98{a[31]}}, a[31:0]} : {98'b0, a[31:0]}) : (s ? {{66{a[63]}}, a} : {66'b0, a});
    am = (A < 0) ? -A : A;
    if (ee) begin
      A = A <<< W;
      B = w ? {98'b0, b[31:0]} : {66'b0, b};
    end else begin
      B = w ? ((s) ? {{98{b[31]}}, b[31:0]} : {98'b0, b[31:0]}) : (s ? {{66{b[63]}}, b} : {66'b0, b});
    end
    lo = s ? -(130'sd1 <<< (W-1)) : 130'sd0;
    hi = s ? (130'sd1 <<< (W-1)) - 130'sd1 : (130'sd1 <<< W) - 130'sd1;
    Q = '0; R = '0;
    if (B == 0) ov = 1'b1;
    else begin
      Q = A / B;
      R = A % B;
      ov = (Q < lo) || (Q > hi);
    end
    early = (B == 0) || (ee ? (am >= B) : ov);
    val = r ? R : Q;
    res = ov ? 64'd0 : (w ? {32'b0, val[31:0]} : val[63:0]);
    if (res == 0) cnd = 3'b001;
    else if (w ? res[31] : res[63]) cnd = 3'b100;
    else cnd = 3'b010;
    lat = early ? 1 : W + 2;
  endfunction

  task automatic run_op(input logic [63:0] a, input logic [63:0] b, input logic s,
      input logic w, input logic e, input logic r, input string tag);
    logic [63:0] er; logic eo; logic [2:0] ec; int el; int n;
    ref_op(a, b, s, w, e, r, er, eo, ec, el);
    @(negedge clk);
    opa = a; opb = b; sgn = s; word = w; ext = e; rem_sel = r; start = 1'b1;
    n = 0;
    do begin
      @(negedge clk);
      n++;
      if (n == 1) start = 1'b0;
    end while (!done && n < 100);
    chk(n == el, {tag, " R9 latency"}, 64'(n), 64'(el));
    chk(result == er, {tag, " result"}, result, er);
    chk(ovf == eo, {tag, " ovf"}, 64'(ovf), 64'(eo));
    chk(cond == ec, {tag, " R10 cond"}, 64'(cond), 64'(ec));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual %h expected %h", 64'd0, 64'd1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [63:0] MIN = 64'h8000_0000_0000_0000;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(busy == 0 && done == 0 && ovf == 0, "R1 flags", {busy, done, ovf}, 0);
    chk(result == 0 && cond == 0, "R1 data", result, 0);
    rst_n = 1'b1;

    run_op(64'd100, 64'd7, 0, 0, 0, 0, "R2 udiv");
    run_op(64'd100, 64'd7, 0, 0, 0, 1, "R2 umod");
    run_op(64'hFFFF_FFFF_FFFF_FFFF, 64'd3, 0, 0, 0, 0, "R2 udiv max");
    run_op(-64'd100, 64'd7, 1, 0, 0, 0, "R3 sdiv neg");
    run_op(-64'd100, 64'd7, 1, 0, 0, 1, "R3 smod neg");
    run_op(64'd100, -64'd7, 1, 0, 0, 1, "R3 smod negdivisor");
    run_op(MIN, 64'd2, 1, 0, 0, 0, "R3 sdiv min");
    run_op(64'hDEAD_BEEF_0000_0064, 64'h1234_5678_FFFF_FFF9, 1, 1, 0, 0, "R4 word sdiv");
    run_op(64'hDEAD_BEEF_0000_0064, 64'h1234_5678_0000_0007, 0, 1, 0, 1, "R4 word umod");
    run_op(64'd55, 64'd0, 0, 0, 0, 0, "R5 udiv zero");
    run_op(64'd55, 64'hFFFF_FFFF_0000_0000, 1, 1, 0, 1, "R5 word smod zero");
    run_op(64'd55, 64'd0, 1, 0, 1, 0, "R5 ext zero");
    run_op(MIN, '1, 1, 0, 0, 0, "R6 sdiv min/-1");
    run_op(MIN, '1, 1, 0, 0, 1, "R6 smod min/-1");
    run_op(64'h5555_5555_8000_0000, 64'h0000_0000_FFFF_FFFF, 1, 1, 0, 0, "R6 word min/-1");
    run_op(MIN, '1, 0, 0, 0, 0, "R6 unsigned same ops");
    run_op(64'd1, 64'd2, 0, 0, 1, 0, "R7 uext fit");
    run_op(64'd9, 64'd9, 0, 0, 1, 0, "R7 uext equal");
    run_op(64'd3, 64'd7, 0, 1, 1, 0, "R7 word uext");
    run_op('1, 64'd2, 1, 0, 1, 0, "R8 sext -2^63 fits");
    run_op(64'd1, 64'd2, 1, 0, 1, 0, "R8 sext +2^63 overflow");
    run_op(64'h0000_0000_FFFF_FFFF, 64'd2, 1, 1, 1, 0, "R8 word sext");
    run_op(-64'd5, 64'd3, 1, 0, 1, 0, "R8 sext big");
    run_op(64'd100, 64'd7, 0, 0, 1, 1, "R11 ext ignored umod");
    run_op(-64'd100, 64'd7, 1, 1, 1, 1, "R11 ext ignored smod");

    // R9 start while busy is ignored
    begin
      int n = 0;
      @(negedge clk);
      opa = 64'd1000; opb = 64'd3; sgn = 0; word = 0; ext = 0; rem_sel = 0; start = 1'b1;
      do begin
        @(negedge clk);
        n++;
        if (n == 1) start = 1'b0;
        if (n == 3) begin
          chk(busy == 1'b1, "R9 busy mid-run", 64'(busy), 64'd1);
          opa = 64'd5; opb = 64'd1; start = 1'b1;
        end
        if (n == 4) start = 1'b0;
      end while (!done && n < 100);
      chk(n == 66, "R9 ignored start latency", 64'(n), 64'd66);
      chk(result == 64'd333, "R9 ignored start result", result, 64'd333);
    end

    for (int i = 0; i < 300; i++) begin
      logic [63:0] a, b;
      logic s, w, e, r;
      a = {$urandom, $urandom};
      b = {$urandom, $urandom};
      s = $urandom_range(0, 1); w = $urandom_range(0, 1);
      e = ($urandom_range(0, 2) == 0); r = $urandom_range(0, 1);
      if ($urandom_range(0, 3) == 0) b = b >> $urandom_range(0, 63);
      if ($urandom_range(0, 3) == 0) a = a >> $urandom_range(0, 63);
      if (e && $urandom_range(0, 1)) a = a >> $urandom_range(2, 40);
      if ($urandom_range(0, 30) == 0) b = '0;
      if ($urandom_range(0, 30) == 0) begin a = MIN; b = '1; end
      run_op(a, b, s, w, e, r, "R2 R3 R4 R7 R8 random");
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule